// File: doc/BRIEF.md
# Bit-Addressed Serial Register Port

This block is a peripheral port on a one-bit serial register bus. The host reaches it one bit at a time. A 5-bit select names one of 32 bit positions, and an active-low chip select gates every access. On a write, a one-cycle strobe moves the single data bit into the addressed position. On a read, the addressed position is returned on a single read-data line. In normal mode, the upper half of the space is a bank of general-purpose pins and the lower half goes to neighbouring interrupt logic.

Pin direction has no register of its own. A pin starts as an input. The first write to a pin makes it an output, and it stays an output until the next hardware or software reset. Position 0 holds a mode flag. When the flag is set, positions 1 to 30 go to the neighbouring timer logic through a small internal port, and a write of one to position 31 is a software reset of the pin bank. The asynchronous reset is released in step with the clock.

Top module: `sbp_port`

## Requirements
- R1: The 5-bit select addresses 32 positions. In normal mode, positions 16 to 31 map to pins 0 to 15 (pin index = select - 16).
- R2: While bus_cs_n is high, the strobe has no effect on any state or on ext_we, and bus_rdat and bus_rden are both 0.
- R3: When the strobe is high with bus_cs_n low and a pin position is selected, the pin's output latch takes bus_wdat at that clock edge.
- R4: bus_rden equals not bus_cs_n. bus_rdat returns the addressed bit in the same cycle: the mode flag at position 0, the ext_rdata input for internal positions, 0 for position 31 in timer mode, and the pin's sampled level for pin positions (sampled through one register).
- R5: After reset, every gpio_oe bit is 0, every gpio_o bit is 0, and ext_tmode is 0.
- R6: A write to a pin position sets that pin's gpio_oe bit, whatever data bit is written. Only a reset clears it.
- R7: In timer mode, writing 1 to position 31 clears all gpio_oe and gpio_o bits at that edge. Writing 0 there has no effect.
- R8: A write to position 0 loads bus_wdat into the mode flag, shown on ext_tmode (1 = timer mode).
- R9: In timer mode, writes to positions 1 to 30 go to the internal port and leave every pin unchanged.
- R10: ext_we is high in exactly the cycles where an enabled strobe targets an internal position (1 to 15 in normal mode, 1 to 30 in timer mode). ext_sel follows bus_sel and ext_wdata follows bus_wdat.
- R11: After rst_n rises, state stays in reset for two more clock edges. A write at either of those edges is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_sel | input | 5 | Bit position select |
| bus_stb | input | 1 | One-cycle write strobe |
| bus_wdat | input | 1 | Serial write data bit |
| bus_rdat | output | 1 | Serial read data bit |
| bus_rden | output | 1 | High while read data is driven |
| gpio_i | input | 16 | Pin levels |
| gpio_o | output | 16 | Output latches |
| gpio_oe | output | 16 | Pin output enables |
| ext_sel | output | 5 | Position forwarded to internal logic |
| ext_we | output | 1 | Write strobe to internal logic |
| ext_wdata | output | 1 | Write bit to internal logic |
| ext_tmode | output | 1 | Mode flag (1 = timer mode) |
| ext_rdata | input | 1 | Read bit from internal logic |

## Verification
The bench attacks the sticky direction rule by writing zeros to pins. A design that derived direction from the data would leave such a pin as an input. It writes to pin positions while in timer mode, where a decoder that ignored the mode would corrupt a latch. It writes 0 and then 1 to position 31: a design that treated any write there as a reset would clear the bank on the zero. It also strobes with chip select high and writes in the cycles just after reset release, where a missing gate or an early release would change the pins.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_MODE,
    RG_EXT,
    RG_GPIO,
    RG_SRST
  } sbp_region_e;
endpackage

// File: rtl/sbp_rst_sync.sv
module sbp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbp_decode.sv
module sbp_decode
  import sbp_pkg::*;
#(
  parameter int SEL_W     = 5,
  parameter int GPIO_BASE = 16
) (
  input  logic             cs_n_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tmode_i,
  output sbp_region_e      region_o
);
  localparam int TOP_POS = (1 << SEL_W) - 1;

  always_comb begin
    region_o = RG_NONE;
    if (!cs_n_i) begin
      if (sel_i == '0)                          region_o = RG_MODE;
      else if (tmode_i)                         region_o = (sel_i == SEL_W'(TOP_POS)) ? RG_SRST : RG_EXT;
      else if (sel_i >= SEL_W'(GPIO_BASE))      region_o = RG_GPIO;
      else                                      region_o = RG_EXT;
    end
  end
endmodule

// File: rtl/sbp_gpio_bank.sv
module sbp_gpio_bank #(
  parameter int SEL_W     = 5,
  parameter int GPIO_BASE = 16,
  parameter int N_GPIO    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              srst_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wdat_i,
  input  logic [N_GPIO-1:0] pin_i,
  output logic [N_GPIO-1:0] out_o,
  output logic [N_GPIO-1:0] oe_o,
  output logic [N_GPIO-1:0] smp_o
);
  logic [N_GPIO-1:0] out_d, oe_d;

  for (genvar i = 0; i < N_GPIO; i++) begin : g_pin
    logic hit;
    assign hit = we_i && (sel_i == SEL_W'(GPIO_BASE + i));

    always_comb begin
      out_d[i] = out_o[i];
      oe_d[i]  = oe_o[i];
      if (srst_i) begin
        out_d[i] = 1'b0;
        oe_d[i]  = 1'b0;
      end else if (hit) begin
        out_d[i] = wdat_i;
        oe_d[i]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_o <= '0;
      oe_o  <= '0;
      smp_o <= '0;
    end else begin
      out_o <= out_d;
      oe_o  <= oe_d;
      smp_o <= pin_i;
    end
  end

  // R6: an enable bit only falls on a software reset
  a_r6_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_i |=> ((oe_o & $past(oe_o)) == $past(oe_o)));

  // R3: the addressed latch takes the written bit
  a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !srst_i && sel_i >= SEL_W'(GPIO_BASE))
      |=> out_o[$past(sel_i) - SEL_W'(GPIO_BASE)] == $past(wdat_i));

  // R7: software reset empties the bank
  a_r7_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (oe_o == '0 && out_o == '0));
endmodule

// File: rtl/sbp_port.sv
module sbp_port
  import sbp_pkg::*;
#(
  parameter int SEL_W     = 5,
  parameter int GPIO_BASE = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_cs_n,
  input  logic [SEL_W-1:0]                  bus_sel,
  input  logic                              bus_stb,
  input  logic                              bus_wdat,
  output logic                              bus_rdat,
  output logic                              bus_rden,
  input  logic [(1<<SEL_W)-GPIO_BASE-1:0]   gpio_i,
  output logic [(1<<SEL_W)-GPIO_BASE-1:0]   gpio_o,
  output logic [(1<<SEL_W)-GPIO_BASE-1:0]   gpio_oe,
  output logic [SEL_W-1:0]                  ext_sel,
  output logic                              ext_we,
  output logic                              ext_wdata,
  output logic                              ext_tmode,
  input  logic                              ext_rdata
);
  localparam int N_BITS = 1 << SEL_W;
  localparam int N_GPIO = N_BITS - GPIO_BASE;

  logic              rst_i_n;
  sbp_region_e       region;
  logic              wr_en, mode_we, gpio_we, soft_rst;
  logic              mode_q, mode_d;
  logic [N_GPIO-1:0] pin_smp;

  sbp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  sbp_decode #(.SEL_W(SEL_W), .GPIO_BASE(GPIO_BASE)) u_dec (
    .cs_n_i(bus_cs_n), .sel_i(bus_sel), .tmode_i(mode_q), .region_o(region)
  );

  assign wr_en    = bus_stb && (region != RG_NONE);
  assign mode_we  = wr_en && (region == RG_MODE);
  assign gpio_we  = wr_en && (region == RG_GPIO);
  assign soft_rst = wr_en && (region == RG_SRST) && bus_wdat;
  assign ext_we   = wr_en && (region == RG_EXT);

  assign ext_sel   = bus_sel;
  assign ext_wdata = bus_wdat;
  assign ext_tmode = mode_q;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = bus_wdat;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_q <= 1'b0;
    else          mode_q <= mode_d;
  end

  sbp_gpio_bank #(.SEL_W(SEL_W), .GPIO_BASE(GPIO_BASE), .N_GPIO(N_GPIO)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .we_i(gpio_we), .srst_i(soft_rst),
    .sel_i(bus_sel), .wdat_i(bus_wdat), .pin_i(gpio_i),
    .out_o(gpio_o), .oe_o(gpio_oe), .smp_o(pin_smp)
  );

  always_comb begin
    bus_rden = !bus_cs_n;
    unique case (region)
      RG_MODE: bus_rdat = mode_q;
      RG_EXT:  bus_rdat = ext_rdata;
      RG_GPIO: bus_rdat = pin_smp[bus_sel - SEL_W'(GPIO_BASE)];
      default: bus_rdat = 1'b0;
    endcase
  end

  // R2: a deselected port is silent
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_cs_n |-> (!bus_rden && !bus_rdat && !ext_we));

  // R8: mode flag follows a write to position 0
  a_r8_mode_load: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!bus_cs_n && bus_stb && bus_sel == '0) |=> (ext_tmode == $past(bus_wdat)));

  // R10: at most one write target per cycle
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({ext_we, gpio_we, soft_rst, mode_we}));

  // R9: timer mode leaves the pins alone
  a_r9_tmode_pins_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ext_tmode && !soft_rst) |=> $stable(gpio_o) && $stable(gpio_oe));
endmodule

// File: tb/sbp_port_tb.sv
module sbp_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, stb, wdat, rdat, rden;
  logic [4:0]  sel, esel;
  logic [15:0] gpi, gpo, gpoe, pads;
  logic        ewe, ewd, etm, erd;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_oe, m_o, m_in;
  logic        m_mode;
  int          m_hold;

  always #10 clk = ~clk;

  assign gpi = (gpoe & gpo) | (~gpoe & pads);

  sbp_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_sel(sel), .bus_stb(stb),
    .bus_wdat(wdat), .bus_rdat(rdat), .bus_rden(rden), .gpio_i(gpi),
    .gpio_o(gpo), .gpio_oe(gpoe), .ext_sel(esel), .ext_we(ewe),
    .ext_wdata(ewd), .ext_tmode(etm), .ext_rdata(erd)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_rd();
    if (cs_n) return 1'b0;
    if (sel == 0) return m_mode;
    if (m_mode) return (sel == 31) ? 1'b0 : erd;
    if (sel < 16) return erd;
    return m_in[sel - 16];
  endfunction

  function automatic logic exp_we();
    if (cs_n || !stb || sel == 0) return 1'b0;
    return m_mode ? (sel != 31) : (sel < 16);
  endfunction

  // behavioural model, advanced on each edge
  always @(posedge clk) begin
    logic [15:0] pad_now;
    cyc++;
    pad_now = (m_oe & m_o) | (~m_oe & pads);
    if (!rst_n) begin
      m_hold = 0; m_oe = 0; m_o = 0; m_in = 0; m_mode = 0;
    end else if (m_hold < 2) begin
      m_hold++;
    end else begin
      m_in = pad_now;
      if (!cs_n && stb) begin
        if (sel == 0) m_mode = wdat;
        else if (m_mode && sel == 31 && wdat) begin m_oe = 0; m_o = 0; end
        else if (!m_mode && sel >= 16) begin m_oe[sel-16] = 1'b1; m_o[sel-16] = wdat; end
      end
    end
  end

  // compare every cycle, after the drivers have settled
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6/R7 oe", gpoe, m_oe);
      chk("R3 latch", gpo, m_o);
      chk("R8 mode", {15'd0, etm}, {15'd0, m_mode});
      chk("R4/R2 rdat", {15'd0, rdat}, {15'd0, exp_rd()});
      chk("R2/R4 rden", {15'd0, rden}, {15'd0, !cs_n});
      chk("R10 ext_we", {15'd0, ewe}, {15'd0, exp_we()});
      chk("R10 ext_sel", {11'd0, esel}, {11'd0, sel});
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic acc(logic c, logic [4:0] s, logic st, logic d);
    @(negedge clk);
    cs_n = c; sel = s; stb = st; wdat = d;
    @(negedge clk);
    stb = 1'b0; cs_n = 1'b1;
  endtask

  task automatic rd(logic [4:0] s, logic exp, string tag);
    @(negedge clk);
    cs_n = 1'b0; sel = s; stb = 1'b0;
    #5 chk(tag, {15'd0, rdat}, {15'd0, exp});
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  initial begin
    rst_n = 0; cs_n = 1; sel = 0; stb = 0; wdat = 0; erd = 0; pads = 16'hA5C3;
    repeat (4) @(negedge clk);
    // R11: write in the first cycle after release is lost
    rst_n = 1; cs_n = 0; sel = 5'd16; stb = 1; wdat = 1;
    @(negedge clk);
    stb = 0; cs_n = 1;
    @(negedge clk);
    #2 chk("R11 held write", gpoe, 16'h0000);
    chk("R5 oe", gpoe, 16'h0000);
    chk("R5 out", gpo, 16'h0000);
    chk("R5 mode", {15'd0, etm}, 16'h0000);
    repeat (2) @(negedge clk);
    rd(5'd16, 1'b1, "R4 pin0 in");
    rd(5'd31, 1'b1, "R1 pin15 in");
    rd(5'd18, 1'b0, "R4 pin2 in");
    acc(0, 5'd18, 1, 1);
    #2 chk("R6 oe set", gpoe, 16'h0004);
    chk("R3 out set", gpo, 16'h0004);
    acc(0, 5'd18, 1, 0);
    #2 chk("R6 oe kept on zero", gpoe, 16'h0004);
    chk("R3 out clear", gpo, 16'h0000);
    rd(5'd18, 1'b0, "R4 output pin read");
    acc(0, 5'd17, 1, 0);
    #2 chk("R6 zero write makes output", gpoe, 16'h0006);
    acc(1, 5'd20, 1, 1);
    #2 chk("R2 deselected write", gpoe, 16'h0006);
    erd = 1;
    @(negedge clk);
    cs_n = 0; sel = 5'd5; stb = 1; wdat = 1;
    #5 chk("R10 ext_we pulse", {15'd0, ewe}, 16'h0001);
    rd(5'd5, 1'b1, "R4 ext read");
    acc(0, 5'd0, 1, 1);
    #2 chk("R8 timer mode on", {15'd0, etm}, 16'h0001);
    rd(5'd0, 1'b1, "R4 mode read");
    acc(0, 5'd20, 1, 1);
    #2 chk("R9 pins untouched", gpoe, 16'h0006);
    acc(0, 5'd31, 1, 0);
    #2 chk("R7 zero no reset", gpoe, 16'h0006);
    acc(0, 5'd31, 1, 1);
    #2 chk("R7 soft reset oe", gpoe, 16'h0000);
    chk("R7 soft reset out", gpo, 16'h0000);
    acc(0, 5'd0, 1, 0);
    #2 chk("R8 back to normal", {15'd0, etm}, 16'h0000);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cs_n = ($urandom % 4) == 0;
      sel  = 5'($urandom);
      stb  = ($urandom % 2) == 0;
      wdat = 1'($urandom);
      erd  = 1'($urandom);
      pads = 16'($urandom);
    end
    @(negedge clk);
    cs_n = 1; stb = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule